// File: doc/BRIEF.md
# DRAM Strobe Mode Decoder Model

A clocked, synthesizable model of the memory side of an asynchronous-strobe DRAM with two byte lanes. A controller under test is connected to it in simulation or in an emulation build. Each clock the model samples the row strobe, the two column strobes (one per byte lane), write enable, output enable, the address and the input data. It works out which kind of RAS cycle is in progress from the order in which the strobes change. The kinds are a read, a write, a refresh with row address only, a refresh with the column strobe low first, a hidden refresh and a self-refresh. Writes go to a small array, one byte lane at a time. Read data is driven back with a separate enable for each lane.

All strobes are active low. Each pin is sampled on a rising clock edge. Every output is registered, so the response to a pin change is visible right after the first rising edge that samples the change. The storage word is addressed by a row taken from the address pins when RAS falls and a column taken when the first column strobe falls. The row is the low `ROW_BITS` address bits and the column is the low `COL_BITS` address bits. The cycle kind is reported as a 3-bit code: 0 idle, 1 read, 2 write, 3 row-only refresh, 4 column-first refresh, 5 hidden refresh, 6 self-refresh. A one-cycle flag reports strobe orderings that break the protocol.

Top module: `dram_strobe_model`

## Requirements
- R1: With RAS and both column strobes high, the kind is 0 and both lane enables are low. Reset gives the same state, with all storage cleared to zero.
- R2: RAS falling with both column strobes high latches the row and sets kind 3. Both lane enables stay low until a column strobe falls.
- R3: If any column strobe is low when RAS falls and no read data is being held, kind becomes 4. The address and data pins are ignored and nothing is written.
- R4: The first column strobe fall of a page, with WE high, sets kind 1 and loads the word at {row, column} onto the data outputs. The low lane enable follows the low-lane strobe being low and the high lane enable follows the high-lane strobe being low, both only while OE is low.
- R5: The first column strobe fall with WE low sets kind 2 and writes only the lanes whose strobes are low, from the input data. Both lane enables stay low.
- R6: If RAS rises while a column strobe is still low after a read, the read data and its enables are kept. A fall of RAS in that state sets kind 5 and still drives the data.
- R7: When kind 4 has held with RAS low for SELF_CYCLES further clocks, kind becomes 6.
- R8: The column is latched at the earlier of the two strobe falls. A strobe that falls later in the same page adds its own lane at that column: it writes the lane in a write and enables the lane in a read.
- R9: Read data stays on the outputs after the column strobes rise. It changes only at the next first column strobe fall. The lane enables drop while OE is high and return when OE goes low, and they clear when all strobes are high.
- R10: The violation output is high for one cycle when RAS and a column strobe fall at the same sample, and when WE changes while a column strobe stays low in a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rasN | input | 1 | Row strobe, active low |
| lcasN | input | 1 | Column strobe for data bits 7:0, active low |
| ucasN | input | 1 | Column strobe for data bits 15:8, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dIn | input | 2*LANE_W | Write data, two lanes |
| dOut | output | 2*LANE_W | Read data, two lanes |
| loOe | output | 1 | Drive enable for bits 7:0 |
| hiOe | output | 1 | Drive enable for bits 15:8 |
| cycleKind | output | 3 | Decoded cycle kind code |
| violation | output | 1 | One-cycle protocol violation pulse |

## Verification
A wrong cycle kind shows on `cycleKind` in the sample right after the strobe edge that decided it. A bad held-lane state shows just as quickly as an enable that is driven during a write or refresh, or that is missing after a strobe rises. A wrong row or column latch is only seen later, when the word is read back: the wrong lane or the wrong word comes out at the next read of that address. A miscounted self-refresh timer shows as kind 6 arriving one or more clocks early or late against the bench's own count.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

  typedef enum logic [2:0] {
    K_IDLE    = 3'd0,
    K_READ    = 3'd1,
    K_WRITE   = 3'd2,
    K_RASONLY = 3'd3,
    K_CBR     = 3'd4,
    K_HIDDEN  = 3'd5,
    K_SELF    = 3'd6
  } kind_e;

  typedef struct packed {
    logic rowLoad;
    logic colLoad;
    logic useAddrCol;
    logic rdLoad;
    logic wrLo;
    logic wrHi;
  } dpStrobe_t;

endpackage

// File: rtl/dsm_ctrl.sv
module dsm_ctrl
  import dsm_pkg::*;
#(
  parameter int SELF_CYCLES = 25000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rasN,
  input  logic      lcasN,
  input  logic      ucasN,
  input  logic      weN,
  input  logic      oeN,
  output dpStrobe_t st,
  output kind_e     kindQ,
  output logic      loOe,
  output logic      hiOe,
  output logic      violation
);

  localparam int CW = $clog2(SELF_CYCLES + 1);

  logic pRas, pL, pU, pWe, oeQ;
  logic holdLo, holdHi;
  logic [CW-1:0] selfCnt;

  logic standby, rasFall, anyCasLow, firstFall, joinL, joinU, pageOk;

  always_comb begin
    standby   = rasN & lcasN & ucasN;
    rasFall   = pRas & ~rasN;
    anyCasLow = ~lcasN | ~ucasN;
    firstFall = pL & pU & anyCasLow;
    joinL     = pL & ~lcasN & ~pU;
    joinU     = pU & ~ucasN & ~pL;
    pageOk    = (kindQ == K_RASONLY) || (kindQ == K_READ) || (kindQ == K_WRITE);

    st = '0;
    if (rasFall && !anyCasLow) st.rowLoad = 1'b1;
    if (!standby && !rasFall && !rasN) begin
      if (firstFall && pageOk) begin
        st.colLoad    = 1'b1;
        st.useAddrCol = 1'b1;
        if (!weN) begin
          st.wrLo = ~lcasN;
          st.wrHi = ~ucasN;
        end else begin
          st.rdLoad = 1'b1;
        end
      end else if ((joinL || joinU) && kindQ == K_WRITE && !weN) begin
        st.wrLo = joinL;
        st.wrHi = joinU;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pRas <= 1'b1; pL <= 1'b1; pU <= 1'b1; pWe <= 1'b1; oeQ <= 1'b1;
      holdLo <= 1'b0; holdHi <= 1'b0;
      kindQ <= K_IDLE;
      selfCnt <= '0;
      violation <= 1'b0;
    end else begin
      pRas <= rasN; pL <= lcasN; pU <= ucasN; pWe <= weN; oeQ <= oeN;
      violation <= (rasFall & pL & pU & anyCasLow) |
                   ((kindQ == K_WRITE) & ~rasN & (~pL | ~pU) & anyCasLow & (weN != pWe));
      if (standby) begin
        kindQ <= K_IDLE;
        holdLo <= 1'b0;
        holdHi <= 1'b0;
        selfCnt <= '0;
      end else if (rasFall) begin
        selfCnt <= '0;
        if (anyCasLow) kindQ <= (holdLo || holdHi) ? K_HIDDEN : K_CBR;
        else           kindQ <= K_RASONLY;
      end else if (!rasN) begin
        if (st.colLoad) begin
          kindQ  <= weN ? K_READ : K_WRITE;
          holdLo <= weN & ~lcasN;
          holdHi <= weN & ~ucasN;
        end else if (kindQ == K_READ) begin
          if (joinL) holdLo <= 1'b1;
          if (joinU) holdHi <= 1'b1;
        end
        if (kindQ == K_CBR) begin
          if (selfCnt == CW'(SELF_CYCLES - 1)) kindQ <= K_SELF;
          else selfCnt <= selfCnt + 1'b1;
        end
      end
    end
  end

  assign loOe = holdLo & ~oeQ;
  assign hiOe = holdHi & ~oeQ;

  // R1: all strobes high leaves both lanes undriven and the kind idle
  p_standby_hiz_r1: assert property (@(posedge clk) disable iff (!rstN)
    (rasN && lcasN && ucasN) |=> (!loOe && !hiOe && kindQ == K_IDLE));

  // R3: a refresh with the column strobe first never writes
  p_cbr_no_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (kindQ == K_CBR || kindQ == K_SELF) |-> !(st.wrLo || st.wrHi));

  // R5: a write cycle never drives the lanes
  p_write_hiz_r5: assert property (@(posedge clk) disable iff (!rstN)
    (kindQ == K_WRITE) |-> (!loOe && !hiOe));

  // R7: self-refresh is reached only from a column-first refresh
  p_self_entry_r7: assert property (@(posedge clk) disable iff (!rstN)
    (kindQ == K_SELF && $past(kindQ) != K_SELF) |-> ($past(kindQ) == K_CBR));

  // R9: OE high at a sample removes both enables
  p_oe_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    oeN |=> (!loOe && !hiOe));

endmodule

// File: rtl/dsm_data.sv
module dsm_data
  import dsm_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 3,
  parameter int LANE_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           st,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [2*LANE_W-1:0] dIn,
  output logic [2*LANE_W-1:0] dOut
);

  localparam int IDX_W = ROW_BITS + COL_BITS;
  localparam int DEPTH = 1 << IDX_W;
  localparam int USE_W = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS;

  logic [ROW_BITS-1:0] rowQ;
  logic [COL_BITS-1:0] colQ;
  logic [IDX_W-1:0]    wIdx;
  logic [IDX_W-1:0]    rIdx;
  logic                unusedAddr;

  assign unusedAddr = ^{1'b0, addr[ADDR_W-1:USE_W]};
  assign wIdx = {rowQ, st.useAddrCol ? addr[COL_BITS-1:0] : colQ};
  assign rIdx = {rowQ, addr[COL_BITS-1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowQ <= '0;
      colQ <= '0;
    end else begin
      if (st.rowLoad) rowQ <= addr[ROW_BITS-1:0];
      if (st.colLoad) colQ <= addr[COL_BITS-1:0];
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic              wrEn;
    assign wrEn = (g == 0) ? st.wrLo : st.wrHi;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int i = 0; i < DEPTH; i++) laneMem[i] <= '0;
        dOut[g*LANE_W +: LANE_W] <= '0;
      end else begin
        if (wrEn) laneMem[wIdx] <= dIn[g*LANE_W +: LANE_W];
        if (st.rdLoad) dOut[g*LANE_W +: LANE_W] <= laneMem[rIdx];
      end
    end
  end

  // R5: a read load and a lane write never share a cycle
  p_rd_wr_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    st.rdLoad |-> !(st.wrLo || st.wrHi));

  // R2: the row is never latched in the same cycle as a column
  p_row_col_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    st.rowLoad |-> !st.colLoad);

endmodule

// File: rtl/dram_strobe_model.sv
module dram_strobe_model
  import dsm_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int ROW_BITS    = 2,
  parameter int COL_BITS    = 3,
  parameter int LANE_W      = 8,
  parameter int SELF_CYCLES = 25000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rasN,
  input  logic                lcasN,
  input  logic                ucasN,
  input  logic                weN,
  input  logic                oeN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [2*LANE_W-1:0] dIn,
  output logic [2*LANE_W-1:0] dOut,
  output logic                loOe,
  output logic                hiOe,
  output logic [2:0]          cycleKind,
  output logic                violation
);

  dpStrobe_t st;
  kind_e     kindQ;

  dsm_ctrl #(.SELF_CYCLES(SELF_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .rasN(rasN), .lcasN(lcasN), .ucasN(ucasN),
    .weN(weN), .oeN(oeN), .st(st), .kindQ(kindQ),
    .loOe(loOe), .hiOe(hiOe), .violation(violation)
  );

  dsm_data #(.ADDR_W(ADDR_W), .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .LANE_W(LANE_W)) u_data (
    .clk(clk), .rstN(rstN), .st(st), .addr(addr), .dIn(dIn), .dOut(dOut)
  );

  assign cycleKind = kindQ;

endmodule

// File: tb/sim_dram_strobe_model.sv
module sim_dram_strobe_model;

  localparam int SELF_N = 50;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rasN = 1'b1, lcasN = 1'b1, ucasN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [8:0]  addr = '0;
  logic [15:0] dIn = '0;
  logic [15:0] dOut;
  logic        loOe, hiOe, violation;
  logic [2:0]  cycleKind;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  dram_strobe_model #(.SELF_CYCLES(SELF_N)) u0 (
    .clk(clk), .rstN(rstN), .rasN(rasN), .lcasN(lcasN), .ucasN(ucasN),
    .weN(weN), .oeN(oeN), .addr(addr), .dIn(dIn), .dOut(dOut),
    .loOe(loOe), .hiOe(hiOe), .cycleKind(cycleKind), .violation(violation)
  );

  typedef struct packed {
    logic [4:0]  pins;   // ras, lcas, ucas, we, oe
    logic [8:0]  a;
    logic [15:0] din;
    logic [2:0]  kind;
    logic        lo;
    logic        hi;
    logic [15:0] dat;
    logic        viol;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VEC [NV] = '{
    '{5'b11111, 9'd0, 16'h0000, 3'd0, 1'b0, 1'b0, 16'h0000, 1'b0, 4'd1},  // R1 standby
    '{5'b01111, 9'd1, 16'h0000, 3'd3, 1'b0, 1'b0, 16'h0000, 1'b0, 4'd2},  // R2 row 1
    '{5'b00001, 9'd2, 16'hA1B2, 3'd2, 1'b0, 1'b0, 16'h0000, 1'b0, 4'd5},  // R5 word write
    '{5'b01111, 9'd0, 16'h0000, 3'd2, 1'b0, 1'b0, 16'h0000, 1'b0, 4'd5},
    '{5'b00101, 9'd3, 16'hC3D4, 3'd2, 1'b0, 1'b0, 16'h0000, 1'b0, 4'd5},  // R5 low lane only
    '{5'b01111, 9'd0, 16'h0000, 3'd2, 1'b0, 1'b0, 16'h0000, 1'b0, 4'd5},
    '{5'b11111, 9'd0, 16'h0000, 3'd0, 1'b0, 1'b0, 16'h0000, 1'b0, 4'd1},
    '{5'b01111, 9'd1, 16'h0000, 3'd3, 1'b0, 1'b0, 16'h0000, 1'b0, 4'd2},
    '{5'b00010, 9'd2, 16'h0000, 3'd1, 1'b1, 1'b1, 16'hA1B2, 1'b0, 4'd4},  // R4 word read
    '{5'b01110, 9'd0, 16'h0000, 3'd1, 1'b1, 1'b1, 16'hA1B2, 1'b0, 4'd9},  // R9 hold after rise
    '{5'b01111, 9'd0, 16'h0000, 3'd1, 1'b0, 1'b0, 16'h0000, 1'b0, 4'd9},  // R9 OE high
    '{5'b01110, 9'd0, 16'h0000, 3'd1, 1'b1, 1'b1, 16'hA1B2, 1'b0, 4'd9},  // R9 OE back low
    '{5'b01010, 9'd3, 16'h0000, 3'd1, 1'b0, 1'b1, 16'h00D4, 1'b0, 4'd4},  // R4 high lane only
    '{5'b00010, 9'd5, 16'h0000, 3'd1, 1'b1, 1'b1, 16'h00D4, 1'b0, 4'd8},  // R8 late lane joins
    '{5'b10010, 9'd0, 16'h0000, 3'd1, 1'b1, 1'b1, 16'h00D4, 1'b0, 4'd6},  // R6 RAS up, CAS low
    '{5'b00010, 9'd7, 16'h0000, 3'd5, 1'b1, 1'b1, 16'h00D4, 1'b0, 4'd6},  // R6 hidden refresh
    '{5'b11111, 9'd0, 16'h0000, 3'd0, 1'b0, 1'b0, 16'h0000, 1'b0, 4'd1},
    '{5'b10111, 9'd0, 16'h0000, 3'd0, 1'b0, 1'b0, 16'h0000, 1'b0, 4'd3},
    '{5'b00101, 9'd1, 16'hFFFF, 3'd4, 1'b0, 1'b0, 16'h0000, 1'b0, 4'd3},  // R3 refresh, WE low
    '{5'b11111, 9'd0, 16'h0000, 3'd0, 1'b0, 1'b0, 16'h0000, 1'b0, 4'd1},
    '{5'b01111, 9'd1, 16'h0000, 3'd3, 1'b0, 1'b0, 16'h0000, 1'b0, 4'd2},
    '{5'b00010, 9'd2, 16'h0000, 3'd1, 1'b1, 1'b1, 16'hA1B2, 1'b0, 4'd3},  // R3 word untouched
    '{5'b11111, 9'd0, 16'h0000, 3'd0, 1'b0, 1'b0, 16'h0000, 1'b0, 4'd1},
    '{5'b00011, 9'd0, 16'h0000, 3'd4, 1'b0, 1'b0, 16'h0000, 1'b1, 4'd10}, // R10 same-sample fall
    '{5'b11111, 9'd0, 16'h0000, 3'd0, 1'b0, 1'b0, 16'h0000, 1'b0, 4'd10},
    '{5'b01101, 9'd0, 16'h0000, 3'd3, 1'b0, 1'b0, 16'h0000, 1'b0, 4'd2},
    '{5'b00001, 9'd0, 16'h1234, 3'd2, 1'b0, 1'b0, 16'h0000, 1'b0, 4'd5},
    '{5'b00011, 9'd0, 16'h1234, 3'd2, 1'b0, 1'b0, 16'h0000, 1'b1, 4'd10}, // R10 WE moves in write
    '{5'b11111, 9'd0, 16'h0000, 3'd0, 1'b0, 1'b0, 16'h0000, 1'b0, 4'd1}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] p, input logic [8:0] a, input logic [15:0] d);
    @(negedge clk);
    {rasN, lcasN, ucasN, weN, oeN} = p;
    addr = a;
    dIn = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(cycleKind == 3'd0 && !loOe && !hiOe && !violation, "R1 reset",
        {27'd0, cycleKind, loOe, hiOe}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      drive(VEC[i].pins, VEC[i].a, VEC[i].din);
      tag = $sformatf("R%0d step %0d", VEC[i].req, i);
      chk(cycleKind == VEC[i].kind, {tag, " kind"}, {29'd0, cycleKind}, {29'd0, VEC[i].kind});
      chk(loOe == VEC[i].lo && hiOe == VEC[i].hi, {tag, " enables"},
          {30'd0, loOe, hiOe}, {30'd0, VEC[i].lo, VEC[i].hi});
      chk(violation == VEC[i].viol, {tag, " violation"}, {31'd0, violation}, {31'd0, VEC[i].viol});
      if (VEC[i].lo || VEC[i].hi)
        chk(dOut == VEC[i].dat, {tag, " data"}, {16'd0, dOut}, {16'd0, VEC[i].dat});
    end

    // R7: self-refresh entry after SELF_N further clocks with RAS low
    drive(5'b10111, 9'd0, 16'h0);
    drive(5'b00111, 9'd0, 16'h0);
    chk(cycleKind == 3'd4, "R7 refresh start", {29'd0, cycleKind}, 32'd4);
    for (int k = 1; k < SELF_N; k++) drive(5'b00111, 9'd0, 16'h0);
    chk(cycleKind == 3'd4, "R7 one clock before entry", {29'd0, cycleKind}, 32'd4);
    drive(5'b00111, 9'd0, 16'h0);
    chk(cycleKind == 3'd6, "R7 self-refresh", {29'd0, cycleKind}, 32'd6);
    chk(!loOe && !hiOe, "R7 lanes undriven", {30'd0, loOe, hiOe}, 32'd0);
    drive(5'b11111, 9'd0, 16'h0);
    chk(cycleKind == 3'd0, "R1 exit to idle", {29'd0, cycleKind}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule